// File: doc/BRIEF.md
# Vertical sync timing meter

This block times an incoming vertical sync stream against the horizontal sync stream and a free-running crystal clock, all sampled in the crystal clock domain. Once per frame it reports two numbers: the frame period, presented as a 4-bit upper part and an 8-bit lower part, and the width of the true vertical sync pulse as a 7-bit value. For interlaced input a frame is two fields, so the period spans two vertical leading edges.

A units input selects what is counted. Either it counts horizontal lines or it counts ticks of the crystal clock divided by 512. In line units a second input chooses how a line is counted. It can be an integer count of horizontal sync rising edges, or a timed count that replays the last measured line length from each vertical leading edge. The timed count can be off by one against the integer count. Short dips in the sync pulse are treated as serrations and do not end the pulse. A vertical rise that comes less than half a line after the previous vertical edge never starts a frame. The result registers change together on a latching vertical leading edge and hold steady for the rest of the frame.

Top module: `vsync_meter`

## Requirements
- R1: While reset is asserted and afterwards until the first latching leading edge, the period parts and the width read 0.
- R2: With units at 0 (lines) and line mode at 0 (integer), the period equals the number of horizontal sync rising edges in the cycles after one latching vertical leading edge up to and including the next, read as 256*upper + lower.
- R3: With interlace at 1, only every second vertical leading edge latches results, so the period covers two fields. The width comes from the pulse of the first field of the pair. The edge between the two fields leaves the outputs unchanged.
- R4: The width counts unit ticks in the cycles strictly between the leading edge and the final falling edge of the pulse. A low dip that rises again less than half a measured line after it fell neither ends nor splits the pulse.
- R5: A vertical rise less than half a measured line after the previous vertical edge never starts or latches a frame.
- R6: With units at 1, both values count ticks of the crystal clock divided by 512. Each tick lasts one cycle, so a window of N cycles holds floor(N/512) or floor(N/512)+1 ticks.
- R7: With units at 0 and line mode at 1, line ticks fall at whole multiples of the last measured horizontal period after each vertical leading edge. A frame whose leading edge moves earlier within the line therefore reports one line fewer than the integer count.
- R8: The period saturates at 4095 and the width at 127 instead of wrapping.
- R9: The outputs change only on a latching leading edge, where they take the values of the frame just completed. Between latching edges they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Vertical sync, active high |
| interlaced | input | 1 | 1: a frame is two fields |
| unit_sel | input | 1 | 0: line units, 1: crystal/512 units |
| count_mode | input | 1 | Line units only. 0: integer edge count, 1: timed count |
| period_hi | output | 4 | Frame period, upper four bits |
| period_lo | output | 8 | Frame period, lower eight bits |
| vsync_width | output | 7 | True vertical sync width |

## Verification
The bench shifts the vertical leading edge to a different place within the line from one frame to the next. An integer counter and a timed counter then disagree by exactly one line, so a design that mixed up the two line modes reports the wrong period. Pulses carrying several short serration dips catch a width that restarts or stops at the first dip. The interlaced pairs catch a design that latches on every field, or that takes the width from the second field. A frame of more than 4095 lines with a 130-line pulse catches counters that wrap instead of saturating. In crystal units the bench accepts only the two tick counts that the frame length in cycles allows.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  typedef enum logic {
    UNIT_LINES = 1'b0,
    UNIT_XTAL  = 1'b1
  } unit_e;

  typedef enum logic {
    LINE_EDGES = 1'b0,
    LINE_TIMED = 1'b1
  } line_mode_e;
endpackage

// File: rtl/vsm_tick_gen.sv
module vsm_tick_gen
  import vsm_pkg::*;
#(
  parameter int DIV_W  = 9,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              vs_lead,
  input  unit_e             unit_sel,
  input  line_mode_e        line_mode,
  output logic              unit_tick,
  output logic [LINE_W-1:0] half_line
);
  localparam logic [LINE_W-1:0] LMAX  = '1;
  localparam logic [LINE_W-1:0] LONE  = 1;
  localparam logic [LINE_W:0]   LONEX = 1;
  localparam logic [DIV_W-1:0]  DONE  = 1;

  logic              hs_q;
  logic              hs_rise;
  logic [DIV_W-1:0]  pre_q, pre_d;
  logic [LINE_W-1:0] hp_q, hp_d, hp_inc;
  logic [LINE_W-1:0] len_q, len_d;
  logic [LINE_W-1:0] lt_q, lt_d, lt_inc;
  logic              xtal_tick, timed_tick;

  always_comb begin
    hs_rise    = hsync_in && !hs_q;
    xtal_tick  = &pre_q;
    pre_d      = pre_q + DONE;
    hp_inc     = (hp_q == LMAX) ? LMAX : hp_q + LONE;
    hp_d       = hs_rise ? '0 : hp_inc;
    len_d      = hs_rise ? hp_inc : len_q;
    timed_tick = (len_q != '0) && (({1'b0, lt_q} + LONEX) == {1'b0, len_q});
    lt_inc     = (lt_q == LMAX) ? LMAX : lt_q + LONE;
    lt_d       = (vs_lead || timed_tick) ? '0 : lt_inc;
    half_line  = len_q >> 1;
    if (unit_sel == UNIT_XTAL)
      unit_tick = xtal_tick;
    else if (line_mode == LINE_TIMED)
      unit_tick = timed_tick;
    else
      unit_tick = hs_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      pre_q <= '0;
      hp_q  <= '0;
      len_q <= '0;
      lt_q  <= '0;
    end else begin
      hs_q  <= hsync_in;
      pre_q <= pre_d;
      hp_q  <= hp_d;
      len_q <= len_d;
      lt_q  <= lt_d;
    end
  end

  // R6
  xtal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xtal_tick |=> !xtal_tick);

  // R7
  timed_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_lead && !hs_rise && len_q > LONE) |=> !timed_tick);
endmodule

// File: rtl/vsm_vs_edge.sv
module vsm_vs_edge #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_in,
  input  logic [LINE_W-1:0] half_line,
  output logic              start,
  output logic              fall,
  output logic              quiet_low
);
  localparam logic [LINE_W-1:0] LMAX  = '1;
  localparam logic [LINE_W-1:0] LONE  = 1;
  localparam logic [LINE_W:0]   LONEX = 1;

  logic              vs_q;
  logic              rise;
  logic              recent;
  logic [LINE_W-1:0] hl_q, hl_d;

  always_comb begin
    rise      = vsync_in && !vs_q;
    fall      = !vsync_in && vs_q;
    recent    = ({1'b0, hl_q} + LONEX) < {1'b0, half_line};
    start     = rise && !recent;
    quiet_low = !vsync_in && !fall && !recent;
    hl_d      = (rise || fall) ? '0 : ((hl_q == LMAX) ? LMAX : hl_q + LONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q <= 1'b0;
      hl_q <= '0;
    end else begin
      vs_q <= vsync_in;
      hl_q <= hl_d;
    end
  end

  // R5
  serration_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !start);
endmodule

// File: rtl/vsm_frame_acc.sv
module vsm_frame_acc #(
  parameter int PER_W = 12,
  parameter int WID_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_tick,
  input  logic             start,
  input  logic             fall,
  input  logic             quiet_low,
  input  logic             interlaced,
  output logic [PER_W-1:0] period_q,
  output logic [WID_W-1:0] width_q
);
  localparam logic [PER_W-1:0] PMAX = '1;
  localparam logic [PER_W-1:0] PONE = 1;
  localparam logic [WID_W-1:0] WMAX = '1;
  localparam logic [WID_W-1:0] WONE = 1;

  logic             latch;
  logic             field_q, field_d;
  logic             in_pulse_q, in_pulse_d;
  logic [PER_W-1:0] pc_q, pc_d, pc_inc, per_d;
  logic [WID_W-1:0] wcnt_q, wcnt_d, wsnap_q, wsnap_d, wdone_q, wdone_d, wid_d;

  always_comb begin
    latch   = start && (!interlaced || field_q);
    field_d = start ? (interlaced && !field_q) : field_q;
    pc_inc  = (unit_tick && pc_q != PMAX) ? pc_q + PONE : pc_q;
    pc_d    = latch ? '0 : pc_inc;
    per_d   = latch ? pc_inc : period_q;
    wid_d   = latch ? wdone_q : width_q;
    if (latch)
      in_pulse_d = 1'b1;
    else if (in_pulse_q && quiet_low)
      in_pulse_d = 1'b0;
    else
      in_pulse_d = in_pulse_q;
    if (latch)
      wcnt_d = '0;
    else if (in_pulse_q && unit_tick && wcnt_q != WMAX)
      wcnt_d = wcnt_q + WONE;
    else
      wcnt_d = wcnt_q;
    wsnap_d = (in_pulse_q && fall) ? wcnt_q : wsnap_q;
    wdone_d = (in_pulse_q && quiet_low) ? wsnap_q : wdone_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q    <= 1'b0;
      in_pulse_q <= 1'b0;
      pc_q       <= '0;
      wcnt_q     <= '0;
      wsnap_q    <= '0;
      wdone_q    <= '0;
      period_q   <= '0;
      width_q    <= '0;
    end else begin
      field_q    <= field_d;
      in_pulse_q <= in_pulse_d;
      pc_q       <= pc_d;
      wcnt_q     <= wcnt_d;
      wsnap_q    <= wsnap_d;
      wdone_q    <= wdone_d;
      period_q   <= per_d;
      width_q    <= wid_d;
    end
  end

  // R9
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> ($stable(period_q) && $stable(width_q)));

  // R3
  field_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && interlaced && !field_q) |=> $stable(period_q));

  // R8
  period_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q == PMAX && !latch) |=> (pc_q == PMAX));

  // R8
  width_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt_q == WMAX && !latch) |=> (wcnt_q == WMAX));

  // R4
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pulse_q && !quiet_low) |=> in_pulse_q);
endmodule

// File: rtl/vsync_meter.sv
module vsync_meter
  import vsm_pkg::*;
#(
  parameter int DIV_W  = 9,
  parameter int LINE_W = 12,
  parameter int PER_W  = 12,
  parameter int WID_W  = 7,
  localparam int HI_W  = PER_W - 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hsync_in,
  input  logic            vsync_in,
  input  logic            interlaced,
  input  logic            unit_sel,
  input  logic            count_mode,
  output logic [HI_W-1:0] period_hi,
  output logic [7:0]      period_lo,
  output logic [WID_W-1:0] vsync_width
);
  logic              rst_meta, rst_int;
  logic              unit_tick, start, fall, quiet_low;
  logic [LINE_W-1:0] half_line;
  logic [PER_W-1:0]  period_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  vsm_tick_gen #(.DIV_W(DIV_W), .LINE_W(LINE_W)) i_tick (
    .clk       (clk),
    .rst_n     (rst_int),
    .hsync_in  (hsync_in),
    .vs_lead   (start),
    .unit_sel  (unit_e'(unit_sel)),
    .line_mode (line_mode_e'(count_mode)),
    .unit_tick (unit_tick),
    .half_line (half_line)
  );

  vsm_vs_edge #(.LINE_W(LINE_W)) i_edge (
    .clk       (clk),
    .rst_n     (rst_int),
    .vsync_in  (vsync_in),
    .half_line (half_line),
    .start     (start),
    .fall      (fall),
    .quiet_low (quiet_low)
  );

  vsm_frame_acc #(.PER_W(PER_W), .WID_W(WID_W)) i_acc (
    .clk        (clk),
    .rst_n      (rst_int),
    .unit_tick  (unit_tick),
    .start      (start),
    .fall       (fall),
    .quiet_low  (quiet_low),
    .interlaced (interlaced),
    .period_q   (period_q),
    .width_q    (vsync_width)
  );

  assign period_hi = period_q[PER_W-1:8];
  assign period_lo = period_q[7:0];
endmodule

// File: tb/test_vsync_meter.sv
module test_vsync_meter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hsync, vsync, interlaced, unit_sel, count_mode;
  logic [3:0] period_hi;
  logic [7:0] period_lo;
  logic [6:0] vsync_width;
  int total = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vsync_meter i_vsync_meter (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_in    (hsync),
    .vsync_in    (vsync),
    .interlaced  (interlaced),
    .unit_sel    (unit_sel),
    .count_mode  (count_mode),
    .period_hi   (period_hi),
    .period_lo   (period_lo),
    .vsync_width (vsync_width)
  );

  function automatic int per_val();
    return int'(period_hi) * 256 + int'(period_lo);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic idle_lines(input int p, input int n);
    for (int l = 0; l < n; l++)
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        hsync = (c < 2);
        vsync = 1'b0;
      end
  endtask

  // One field: vertical rise at line 0 column off, fall at line vsw column off+1.
  task automatic run_frame(input int p, input int lines, input int off,
                           input int vsw, input bit serr);
    int cap = 0;
    for (int l = 0; l < lines; l++)
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        hsync = (c < 2);
        vsync = (l == 0 && c >= off) || (l > 0 && l < vsw) || (l == vsw && c <= off);
        if (serr && l >= 1 && l < vsw && c >= off + 5 && c < off + 8) vsync = 1'b0;
        if (l == 1 && c == 0) cap = per_val() * 128 + int'(vsync_width);
        if (l == lines - 1 && c == p - 1)
          chk("R9 outputs hold within frame", per_val() * 128 + int'(vsync_width), cap);
      end
  endtask

  initial begin
    int snap;
    rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0;
    interlaced = 1'b0; unit_sel = 1'b0; count_mode = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 reset period_hi", int'(period_hi), 0);
    chk("R1 reset period_lo", int'(period_lo), 0);
    chk("R1 reset width", int'(vsync_width), 0);
    rst_n = 1'b1;
    idle_lines(40, 5);
    chk("R1 no edge yet period", per_val(), 0);

    // Integer line count, serrations
    run_frame(40, 20, 20, 3, 0);
    run_frame(40, 20, 20, 3, 0);
    chk("R2 period lines", per_val(), 20);
    chk("R4 width lines", int'(vsync_width), 3);
    run_frame(40, 25, 10, 5, 1);
    chk("R2 period, next lead earlier", per_val(), 20);
    chk("R4 width", int'(vsync_width), 3);
    run_frame(40, 20, 20, 3, 0);
    chk("R2 period 25 lines", per_val(), 25);
    chk("R4 width with serrations", int'(vsync_width), 5);
    chk("R5 serration rises not frames", per_val(), 25);

    // Timed line count
    count_mode = 1'b1;
    run_frame(40, 20, 20, 3, 0);
    run_frame(40, 20, 20, 4, 1);
    run_frame(40, 20, 10, 3, 0);
    chk("R7 timed period, lead moved earlier", per_val(), 19);
    chk("R7 timed width with serrations", int'(vsync_width), 4);
    run_frame(40, 20, 20, 3, 0);
    chk("R7 timed period, lead moved later", per_val(), 20);
    chk("R7 timed width", int'(vsync_width), 3);

    // Crystal/512 units
    count_mode = 1'b0;
    unit_sel = 1'b1;
    run_frame(40, 20, 20, 3, 0);
    run_frame(40, 60, 20, 20, 0);
    run_frame(40, 20, 20, 3, 0);
    chk_rng("R6 crystal period 2400 cycles", per_val(), 2400 / 512, 2400 / 512 + 1);
    chk_rng("R6 crystal width 800 cycles", int'(vsync_width), 800 / 512, 800 / 512 + 1);

    // Interlaced pairs
    unit_sel = 1'b0;
    interlaced = 1'b1;
    run_frame(40, 20, 20, 3, 0);
    run_frame(40, 25, 20, 4, 0);
    snap = per_val() * 128 + int'(vsync_width);
    run_frame(40, 15, 20, 2, 0);
    chk("R3 second field edge leaves outputs", per_val() * 128 + int'(vsync_width), snap);
    run_frame(40, 20, 20, 3, 0);
    chk("R3 period spans two fields", per_val(), 40);
    chk("R3 width from first field", int'(vsync_width), 4);

    // Saturation
    interlaced = 1'b0;
    run_frame(4, 50, 2, 3, 0);
    run_frame(4, 4200, 2, 130, 0);
    run_frame(4, 50, 2, 3, 0);
    chk("R8 period saturates", per_val(), 4095);
    chk("R8 period upper part", int'(period_hi), 15);
    chk("R8 width saturates", int'(vsync_width), 127);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule